// File: doc/BRIEF.md
# Chainable Periodic Timer Bank

The block holds a bank of independent down-counting timers behind a plain word-wide register bus. Software gives each channel a reload value and sets its enable bit. The channel then counts down to zero, raises a sticky timeout flag, reloads and starts the next period. Each channel drives its own interrupt line, which is high while the flag is set and the channel's interrupt enable is on.

A channel can be cascaded onto the one below it. It then steps once for each expiry of that lower channel, so two timers can measure periods longer than one counter can hold. A global control register switches all counting off, and can hold every timer while an external debug-halt pin is high. Rewriting the reload value never disturbs a running period. The new value is used at the next expiry, and a period restarts at once only when the channel is disabled and then enabled again.

Top module: `tick_bank`

## Requirements
- R1: After reset the global control register reads 0x00000006 (off bit set, freeze clear, fixed bit 2 set), every channel register reads 0, and all interrupt lines are low.
- R2: The global control register is at byte offset 0x000 (bit 0 freeze, bit 1 off, bit 2 reads as a constant 1). Channel n occupies 0x100 + 16*n: reload at +0x0, count at +0x4 (read-only), control at +0x8 (bit 0 enable, bit 1 interrupt enable, bit 2 cascade) and flag at +0xC (bit 0). Reserved bits read 0 and ignore writes. Unmapped words read 0.
- R3: A running, non-cascaded channel decrements once per cycle. In the step after its count reaches 0, it sets its flag and reloads, which gives a period of reload+1 cycles.
- R4: A disabled channel holds its count. In the cycle after its enable goes from 0 to 1, the count takes the reload value.
- R5: Writing the reload value while the channel runs leaves the count untouched. The new value is loaded at the next expiry.
- R6: While the off bit is 1, no channel counts, expires or sets its flag.
- R7: With freeze at 1 and the debug-halt pin high, every count holds. With freeze at 0, the channels keep counting while the pin is high.
- R8: A cascaded channel n (n >= 1) steps only in a cycle in which channel n-1 expires. The cascade bit of channel 0 is stored but has no effect.
- R9: Writing 1 to flag bit 0 clears the flag. Writing 0 leaves it unchanged.
- R10: When an expiry and a clearing write to the same flag fall in one cycle, the flag ends up set.
- R11: Interrupt line n equals flag n AND interrupt enable n. Setting the enable while the flag is already set raises the line in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte address of the accessed word |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| dbg_halt | input | 1 | Debug-halt indication used by the freeze control |
| tmr_irq | output | 4 | One interrupt request per channel |

## Verification
A hardware expiry that sets a flag and a software write-1 that clears the same flag can land on the same clock edge. The bench provokes this on channel 1 by counting cycles from a known reload and issuing the clearing write exactly on the edge where the count leaves zero. The result is judged by reading the flag back as 1 and the count back at its reload value. A second coincidence is the expiry of a cascaded channel in the same cycle as its lower neighbour. The bench checks it by confirming that the upper channel holds while the lower one runs and then reloads together with it.

// File: rtl/tick_bank_pkg.sv
package tick_bank_pkg;

  // bytes per channel slot; the four words inside a slot are picked by address bits [3:2]
  localparam int unsigned SLOT_BYTES = 16;

  typedef enum logic [1:0] {
    FLD_LOAD = 2'd0,
    FLD_CUR  = 2'd1,
    FLD_CTRL = 2'd2,
    FLD_FLAG = 2'd3
  } chan_fld_e;

  // channel control bit positions
  localparam int unsigned CTL_EN    = 0;
  localparam int unsigned CTL_IE    = 1;
  localparam int unsigned CTL_CHAIN = 2;

  // global control bit positions
  localparam int unsigned MC_FREEZE = 0;
  localparam int unsigned MC_OFF    = 1;
  localparam int unsigned MC_FIXED  = 2;

endpackage

// File: rtl/tick_mctl.sv
module tick_mctl
  import tick_bank_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [1:0]    wdata,
  input  logic          dbg_halt,
  output logic [DW-1:0] rdata,
  output logic          run_ok
);

  logic frz_q;
  logic off_q;

  // counting is allowed unless switched off or frozen by the debug pin
  function automatic logic may_count(input logic off, input logic frz, input logic dbg);
    return !off && !(frz && dbg);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frz_q <= 1'b0;
      off_q <= 1'b1;
    end else if (wr) begin
      frz_q <= wdata[MC_FREEZE];
      off_q <= wdata[MC_OFF];
    end
  end

  assign run_ok = may_count(off_q, frz_q, dbg_halt);

  always_comb begin
    rdata            = '0;
    rdata[MC_FREEZE] = frz_q;
    rdata[MC_OFF]    = off_q;
    rdata[MC_FIXED]  = 1'b1;
  end

  assert_mctl_update_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (off_q == $past(wdata[MC_OFF])) && (frz_q == $past(wdata[MC_FREEZE])));

endmodule

// File: rtl/tick_chan.sv
module tick_chan
  import tick_bank_pkg::*;
#(
  parameter int unsigned DW       = 32,
  parameter bit          CHAIN_OK = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_load,
  input  logic          wr_ctrl,
  input  logic          wr_flag,
  input  logic [DW-1:0] wdata,
  input  chan_fld_e     rd_fld,
  input  logic          run_ok,
  input  logic          prev_expire,
  output logic [DW-1:0] rdata,
  output logic          expire,
  output logic          irq
);

  logic [DW-1:0] load_q;
  logic [DW-1:0] count_q;
  logic          en_q;
  logic          ie_q;
  logic          chain_q;
  logic          armed_q;
  logic          flag_q;

  logic          chained;
  logic          start;
  logic          step;
  logic          clr_req;

  // next counter value: load on start, wrap to reload at zero, else decrement
  function automatic logic [DW-1:0] next_count(input logic [DW-1:0] cur, input logic [DW-1:0] ld,
                                               input logic st, input logic stp);
    if (st)  return ld;
    if (stp) return (cur == '0) ? ld : cur - 1'b1;
    return cur;
  endfunction

  if (CHAIN_OK) begin : g_chain
    assign chained = chain_q;
  end else begin : g_nochain
    assign chained = 1'b0;
  end

  assign start   = en_q && !armed_q;
  assign step    = en_q && armed_q && run_ok && (!chained || prev_expire);
  assign expire  = step && (count_q == '0);
  assign clr_req = wr_flag && wdata[0];
  assign irq     = flag_q && ie_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q  <= '0;
      count_q <= '0;
      en_q    <= 1'b0;
      ie_q    <= 1'b0;
      chain_q <= 1'b0;
      armed_q <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      if (wr_load) load_q <= wdata;
      if (wr_ctrl) begin
        en_q    <= wdata[CTL_EN];
        ie_q    <= wdata[CTL_IE];
        chain_q <= wdata[CTL_CHAIN];
      end
      armed_q <= en_q;
      count_q <= next_count(count_q, load_q, start, step);
      if (expire)       flag_q <= 1'b1;
      else if (clr_req) flag_q <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    case (rd_fld)
      FLD_LOAD: rdata = load_q;
      FLD_CUR:  rdata = count_q;
      FLD_CTRL: begin
        rdata[CTL_EN]    = en_q;
        rdata[CTL_IE]    = ie_q;
        rdata[CTL_CHAIN] = chain_q;
      end
      default:  rdata[0] = flag_q;
    endcase
  end

  assert_hold_disabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> $stable(count_q));
  assert_start_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !armed_q) |=> (count_q == $past(load_q)));
  assert_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (count_q == $past(load_q)));
  assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> flag_q);
  assert_halted_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_ok && armed_q) |=> $stable(count_q));
  assert_chain_wait_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (chained && !prev_expire && armed_q) |=> $stable(count_q));
  assert_w1c_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !expire) |=> !flag_q);
  assert_flag_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_req && !expire) |=> $stable(flag_q));

endmodule

// File: rtl/tick_bank.sv
module tick_bank
  import tick_bank_pkg::*;
#(
  parameter int unsigned NCH     = 4,
  parameter int unsigned DW      = 32,
  parameter int unsigned AW      = 12,
  parameter int unsigned CH_BASE = 256
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [AW-1:0]  bus_addr,
  input  logic           bus_we,
  input  logic [DW-1:0]  bus_wdata,
  output logic [DW-1:0]  bus_rdata,
  input  logic           dbg_halt,
  output logic [NCH-1:0] tmr_irq
);

  localparam int unsigned SPAN = NCH * SLOT_BYTES;
  localparam int unsigned SW   = AW - 4;

  logic          hit_mctl;
  logic          in_chan;
  logic [AW-1:0] ch_off;
  logic [SW-1:0] ch_slot;
  chan_fld_e     ch_fld;
  logic          run_ok;
  logic [DW-1:0] mctl_rd;
  logic [NCH-1:0] ch_wr;
  logic [NCH-1:0] ch_exp;
  logic [DW-1:0] ch_rd [NCH];

  assign hit_mctl = (bus_addr == '0);
  assign ch_off   = bus_addr - AW'(CH_BASE);
  assign ch_slot  = ch_off[AW-1:4];
  assign ch_fld   = chan_fld_e'(ch_off[3:2]);
  assign in_chan  = (bus_addr >= AW'(CH_BASE)) && (ch_off < AW'(SPAN)) && (ch_off[1:0] == 2'b00);

  tick_mctl #(.DW(DW)) u_mctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (bus_we && hit_mctl),
    .wdata    (bus_wdata[1:0]),
    .dbg_halt (dbg_halt),
    .rdata    (mctl_rd),
    .run_ok   (run_ok)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic prev_exp;
    assign ch_wr[g] = bus_we && in_chan && (ch_slot == SW'(g));
    if (g == 0) begin : g_first
      assign prev_exp = 1'b0;
    end else begin : g_next
      assign prev_exp = ch_exp[g-1];
    end
    tick_chan #(.DW(DW), .CHAIN_OK(g != 0)) u_chan (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_load     (ch_wr[g] && (ch_fld == FLD_LOAD)),
      .wr_ctrl     (ch_wr[g] && (ch_fld == FLD_CTRL)),
      .wr_flag     (ch_wr[g] && (ch_fld == FLD_FLAG)),
      .wdata       (bus_wdata),
      .rd_fld      (ch_fld),
      .run_ok      (run_ok),
      .prev_expire (prev_exp),
      .rdata       (ch_rd[g]),
      .expire      (ch_exp[g]),
      .irq         (tmr_irq[g])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (hit_mctl) bus_rdata = mctl_rd;
    for (int i = 0; i < NCH; i++) begin
      if (in_chan && (ch_slot == SW'(i))) bus_rdata = ch_rd[i];
    end
  end

  assert_single_target_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({bus_we && hit_mctl, ch_wr}));
  assert_off_no_expiry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !run_ok |-> (ch_exp == '0));

endmodule

// File: tb/test_tick_bank.sv
`timescale 1ns/1ps
module test_tick_bank;

  localparam logic [2:0] OP_WR   = 3'd0;
  localparam logic [2:0] OP_IDLE = 3'd1;
  localparam logic [2:0] OP_RD   = 3'd2;
  localparam logic [2:0] OP_IRQ  = 3'd3;
  localparam logic [2:0] OP_DBG  = 3'd4;

  typedef struct packed {
    logic [2:0]  op;
    logic [3:0]  req;
    logic [11:0] addr;
    logic [31:0] data;
  } vec_t;

  localparam int NVEC = 56;
  // channel 0 scenario: R3 period, R9 flag clear, R5 reload update, R11 irq gating,
  // R4 restart, R7 freeze, R6 global off
  localparam vec_t VECS [NVEC] = '{
    '{OP_WR,   4'd0,  12'h000, 32'h0},
    '{OP_WR,   4'd0,  12'h100, 32'd3},
    '{OP_WR,   4'd0,  12'h108, 32'h3},
    '{OP_RD,   4'd4,  12'h104, 32'd0},   // R4 not loaded yet
    '{OP_IDLE, 4'd0,  12'h000, 32'd1},
    '{OP_RD,   4'd4,  12'h104, 32'd3},   // R4 loaded one cycle after enable
    '{OP_IDLE, 4'd0,  12'h000, 32'd3},
    '{OP_RD,   4'd3,  12'h104, 32'd0},   // R3 reached zero
    '{OP_RD,   4'd3,  12'h10C, 32'd0},
    '{OP_IRQ,  4'd11, 12'h000, 32'h0},
    '{OP_IDLE, 4'd0,  12'h000, 32'd1},
    '{OP_RD,   4'd3,  12'h104, 32'd3},   // R3 reload
    '{OP_RD,   4'd3,  12'h10C, 32'd1},
    '{OP_IRQ,  4'd11, 12'h000, 32'h1},
    '{OP_IDLE, 4'd0,  12'h000, 32'd4},
    '{OP_RD,   4'd3,  12'h104, 32'd3},   // R3 period load+1
    '{OP_WR,   4'd0,  12'h10C, 32'h0},
    '{OP_RD,   4'd9,  12'h10C, 32'd1},   // R9 write 0 no effect
    '{OP_WR,   4'd0,  12'h10C, 32'h1},
    '{OP_RD,   4'd9,  12'h10C, 32'd0},   // R9 write 1 clears
    '{OP_IRQ,  4'd11, 12'h000, 32'h0},
    '{OP_WR,   4'd0,  12'h100, 32'd6},
    '{OP_RD,   4'd5,  12'h104, 32'd0},   // R5 no restart
    '{OP_IDLE, 4'd0,  12'h000, 32'd1},
    '{OP_RD,   4'd5,  12'h104, 32'd6},   // R5 new value at expiry
    '{OP_WR,   4'd0,  12'h108, 32'h1},
    '{OP_IRQ,  4'd11, 12'h000, 32'h0},   // R11 flag set, ie off
    '{OP_WR,   4'd0,  12'h108, 32'h3},
    '{OP_IRQ,  4'd11, 12'h000, 32'h1},   // R11 immediate on enable
    '{OP_WR,   4'd0,  12'h108, 32'h2},
    '{OP_IDLE, 4'd0,  12'h000, 32'd2},
    '{OP_RD,   4'd4,  12'h104, 32'd3},   // R4 held while disabled
    '{OP_WR,   4'd0,  12'h108, 32'h3},
    '{OP_IDLE, 4'd0,  12'h000, 32'd1},
    '{OP_RD,   4'd4,  12'h104, 32'd6},   // R4 restart loads
    '{OP_WR,   4'd0,  12'h10C, 32'h1},
    '{OP_WR,   4'd0,  12'h000, 32'h1},
    '{OP_DBG,  4'd0,  12'h000, 32'h1},
    '{OP_IDLE, 4'd0,  12'h000, 32'd3},
    '{OP_RD,   4'd7,  12'h104, 32'd4},   // R7 frozen
    '{OP_DBG,  4'd0,  12'h000, 32'h0},
    '{OP_IDLE, 4'd0,  12'h000, 32'd1},
    '{OP_RD,   4'd7,  12'h104, 32'd3},   // R7 resumes
    '{OP_WR,   4'd0,  12'h000, 32'h0},
    '{OP_DBG,  4'd0,  12'h000, 32'h1},
    '{OP_IDLE, 4'd0,  12'h000, 32'd1},
    '{OP_RD,   4'd7,  12'h104, 32'd1},   // R7 runs with freeze clear
    '{OP_DBG,  4'd0,  12'h000, 32'h0},
    '{OP_WR,   4'd0,  12'h000, 32'h2},
    '{OP_IDLE, 4'd0,  12'h000, 32'd3},
    '{OP_RD,   4'd6,  12'h104, 32'd0},   // R6 stuck at zero
    '{OP_RD,   4'd6,  12'h10C, 32'd0},   // R6 no expiry
    '{OP_WR,   4'd0,  12'h000, 32'h0},
    '{OP_IDLE, 4'd0,  12'h000, 32'd1},
    '{OP_RD,   4'd6,  12'h104, 32'd6},   // R6 expiry after re-enable
    '{OP_RD,   4'd6,  12'h10C, 32'd1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        dbg_halt = 1'b0;
  logic [3:0]  tmr_irq;

  int applied = 0;
  int miss = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  tick_bank i_tick_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .dbg_halt  (dbg_halt),
    .tmr_irq   (tmr_irq)
  );

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_addr  = a;
    bus_wdata = d;
    bus_we    = 1'b1;
    @(negedge clk);
    bus_we    = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [11:0] a, input logic [31:0] e);
    bus_addr = a;
    bus_we   = 1'b0;
    #1;
    applied++;
    if (bus_rdata !== e) begin
      miss++;
      $display("FAIL %s addr %h got %h expected %h", req, a, bus_rdata, e);
    end
  endtask

  task automatic chk_irq(input string req, input logic [3:0] e);
    #1;
    applied++;
    if (tmr_irq !== e) begin
      miss++;
      $display("FAIL %s irq got %b expected %b", req, tmr_irq, e);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1", 12'h000, 32'h6);
    chk("R1", 12'h100, 32'h0);
    chk("R1", 12'h104, 32'h0);
    chk("R1", 12'h108, 32'h0);
    chk("R1", 12'h10C, 32'h0);
    chk("R1", 12'h13C, 32'h0);
    chk_irq("R1", 4'h0);

    for (int k = 0; k < NVEC; k++) begin
      case (VECS[k].op)
        OP_WR:   wr(VECS[k].addr, VECS[k].data);
        OP_IDLE: idle(int'(VECS[k].data));
        OP_RD:   chk($sformatf("R%0d", VECS[k].req), VECS[k].addr, VECS[k].data);
        OP_IRQ:  chk_irq($sformatf("R%0d", VECS[k].req), VECS[k].data[3:0]);
        default: dbg_halt = VECS[k].data[0];
      endcase
    end

    // stop channel 0 and clear its flag
    wr(12'h108, 32'h0);
    wr(12'h10C, 32'h1);

    // R8 cascade: channel 2 on channel 1
    wr(12'h110, 32'd2);
    wr(12'h120, 32'd1);
    wr(12'h128, 32'h5);
    wr(12'h118, 32'h1);
    idle(4);
    chk("R8", 12'h124, 32'd0);
    chk("R3", 12'h11C, 32'd1);
    chk("R8", 12'h12C, 32'd0);
    idle(2);
    chk("R8", 12'h124, 32'd0);
    idle(1);
    chk("R8", 12'h124, 32'd1);
    chk("R8", 12'h12C, 32'd1);
    chk_irq("R11", 4'h0);

    // R10 expiry and clearing write on the same edge
    wr(12'h11C, 32'h1);
    chk("R9", 12'h11C, 32'd0);
    idle(1);
    wr(12'h11C, 32'h1);
    chk("R10", 12'h11C, 32'd1);
    chk("R10", 12'h114, 32'd2);

    // R8 cascade bit on channel 0 has no effect
    wr(12'h100, 32'd1);
    wr(12'h108, 32'h5);
    idle(3);
    chk("R8", 12'h104, 32'd1);
    chk("R8", 12'h10C, 32'd1);
    chk("R2", 12'h108, 32'h5);

    // R2 reserved bits and unmapped words
    wr(12'h138, 32'hFFFF_FFF8);
    chk("R2", 12'h138, 32'h0);
    chk("R2", 12'h13C, 32'h0);
    wr(12'h000, 32'hFFFF_FFFC);
    chk("R2", 12'h000, 32'h4);
    chk("R2", 12'h004, 32'h0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, miss);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      miss++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", applied, miss);
      $finish;
    end
  end

endmodule